// File: doc/BRIEF.md
# Machine Status Register Unit with Supervisor Alias and Double-Trap Gating

This block holds the machine status register and the machine environment configuration register of a 64-bit RISC-V style core. It also presents the supervisor status register as a restricted window onto the same storage. The core's CSR stage drives one access per cycle. Each access carries an address, an operation code, a 64-bit operand and the current privilege level. In the same cycle the block returns the value the register held before the access. The update lands on the next rising clock edge.

The block's main concern is the supervisor double-trap flag. A machine-level write can always change it. A write through the supervisor window changes it only while the double-trap enable in the environment register is on; while that enable is off, the flag keeps whatever value it already held. The block also guards reserved bits. Reserved (WPRI) positions of the status register are never altered by any write, set or clear, to any of the three registers, and they read as zero. Traps, returns, other CSRs and instruction decode belong to other blocks.

Top module: `csr_status_alias`

## Requirements
- R1: After reset every implemented field of the status register and of the environment register is 0.
- R2: The implemented status bits are SIE(1), MIE(3), SPIE(5), MPIE(7), SPP(8), SUM(18), MXR(19), SDT(24) and MDT(42). All other status bits are reserved: they read as 0 through either view and keep their stored value across every access. The environment register implements FIOM(0) and DTE(59) and reads 0 elsewhere.
- R3: Any access to the environment register (address 0x30A) leaves every bit of the status register unchanged.
- R4: A write through the supervisor view (address 0x100) changes only SIE, SPIE, SPP, SUM, MXR and SDT. MIE, MPIE and MDT keep their values.
- R5: A write through the machine view (address 0x300) updates SDT whatever the value of DTE.
- R6: A write through the supervisor view updates SDT only when DTE (bit 59 of the environment register) is 1. When DTE is 0, SDT holds its current value and is not forced to 0.
- R7: When DTE is 0, a supervisor-view read returns SDT as 0. A machine-view read always returns the stored SDT.
- R8: A write that actually updates SDT with the value 1 clears SIE on the same edge. A machine-view write carrying MDT = 1 clears MIE on the same edge.
- R9: The op codes are 0 = read only (no update), 1 = write, 2 = set (old OR operand), 3 = clear (old AND NOT operand). "Old" is the value of the view being accessed. The result then passes through that view's field mask and the SDT gating. With req_valid low nothing changes and both outputs are 0.
- R10: Privilege codes are 0 = user, 1 = supervisor, 3 = machine. The status register at 0x300 and the environment register need machine privilege. The supervisor view needs supervisor or machine privilege. Any other address is illegal. An illegal access raises rsp_illegal, returns 0 and changes no state.
- R11: rsp_rdata shows the pre-access value combinationally in the cycle of the access. The update is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_addr | input | 12 | CSR address |
| req_op | input | 2 | Operation code (read, write, set, clear) |
| req_wdata | input | 64 | Write, set or clear operand |
| req_priv | input | 2 | Privilege level of the access |
| rsp_rdata | output | 64 | Pre-access value of the addressed view |
| rsp_illegal | output | 1 | Access refused for address or privilege |

## Verification
The bench probes the SDT gating from both sides.
- A supervisor write of SDT = 0 while DTE is 0 must leave a stored 1 in place. A design that forces SDT to zero would lose it.
- A supervisor set of SDT while DTE is 0 must change nothing. A design that leaks alias writes would raise SDT.
- Set and clear sequences on the environment register must leave the status register untouched. A design that merges write paths would disturb status bits.
- A supervisor write of all ones must not touch MIE or MDT.
- Writes with SDT or MDT at 1 must drop the matching interrupt enable.

A long random sweep over addresses, privileges, op codes and operands then compares every response against an arithmetic model.

// File: rtl/csr_alias_pkg.sv
package csr_alias_pkg;

  localparam int XLEN   = 64;
  localparam int ADDR_W = 12;
  localparam int PRIV_W = 2;

  typedef logic [XLEN-1:0] xword_t;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  localparam logic [PRIV_W-1:0] PRIV_U = 2'd0;
  localparam logic [PRIV_W-1:0] PRIV_S = 2'd1;
  localparam logic [PRIV_W-1:0] PRIV_M = 2'd3;

  localparam logic [ADDR_W-1:0] ADR_MSTATUS = 12'h300;
  localparam logic [ADDR_W-1:0] ADR_SSTATUS = 12'h100;
  localparam logic [ADDR_W-1:0] ADR_MENVCFG = 12'h30A;

  // field positions in the status word
  localparam int B_SIE  = 1;
  localparam int B_MIE  = 3;
  localparam int B_SPIE = 5;
  localparam int B_MPIE = 7;
  localparam int B_SPP  = 8;
  localparam int B_SUM  = 18;
  localparam int B_MXR  = 19;
  localparam int B_SDT  = 24;
  localparam int B_MDT  = 42;
  // field positions in the environment word
  localparam int B_FIOM = 0;
  localparam int B_DTE  = 59;

  localparam xword_t ONE = xword_t'(1);

  localparam xword_t MST_IMPL = (ONE << B_SIE) | (ONE << B_MIE) | (ONE << B_SPIE) |
                                (ONE << B_MPIE) | (ONE << B_SPP) | (ONE << B_SUM) |
                                (ONE << B_MXR) | (ONE << B_SDT) | (ONE << B_MDT);

  localparam xword_t SST_MASK = (ONE << B_SIE) | (ONE << B_SPIE) | (ONE << B_SPP) |
                                (ONE << B_SUM) | (ONE << B_MXR) | (ONE << B_SDT);

  localparam xword_t ENV_IMPL = (ONE << B_FIOM) | (ONE << B_DTE);

  localparam xword_t SDT_BIT = ONE << B_SDT;

  // read-modify-write arithmetic shared by every register
  function automatic xword_t csr_rmw(input xword_t old_v, input csr_op_e op,
                                     input xword_t operand);
    xword_t r;
    unique case (op)
      OP_WRITE: r = operand;
      OP_SET:   r = old_v | operand;
      OP_CLEAR: r = old_v & ~operand;
      default:  r = old_v;
    endcase
    return r;
  endfunction

  function automatic xword_t mstatus_view(input xword_t stored);
    return stored & MST_IMPL;
  endfunction

  function automatic xword_t sstatus_view(input xword_t stored, input logic dte);
    xword_t v;
    v = stored & SST_MASK;
    if (!dte) v[B_SDT] = 1'b0;
    return v;
  endfunction

  // fields the supervisor view may change, given the double-trap enable
  function automatic xword_t sstatus_wmask(input logic dte);
    return dte ? SST_MASK : (SST_MASK & ~SDT_BIT);
  endfunction

  function automatic xword_t merge_masked(input xword_t stored, input xword_t src,
                                          input xword_t wmask);
    return (stored & ~wmask) | (src & wmask);
  endfunction

endpackage

// File: rtl/csr_alias_decode.sv
module csr_alias_decode
  import csr_alias_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int PW = PRIV_W
) (
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  csr_op_e       req_op,
  input  logic [PW-1:0] req_priv,
  output logic          sel_m,
  output logic          sel_s,
  output logic          sel_e,
  output logic          illegal,
  output logic          wr_m,
  output logic          wr_s,
  output logic          wr_e
);

  logic hit_m, hit_s, hit_e, known, priv_ok, legal, writes;

  always_comb begin
    hit_m   = (req_addr == AW'(ADR_MSTATUS));
    hit_s   = (req_addr == AW'(ADR_SSTATUS));
    hit_e   = (req_addr == AW'(ADR_MENVCFG));
    known   = hit_m | hit_s | hit_e;
    priv_ok = hit_s ? ((req_priv == PW'(PRIV_S)) || (req_priv == PW'(PRIV_M)))
                    : (req_priv == PW'(PRIV_M));
    legal   = req_valid && known && priv_ok;
    illegal = req_valid && !(known && priv_ok);
    writes  = (req_op != OP_READ);
    sel_m   = legal && hit_m;
    sel_s   = legal && hit_s;
    sel_e   = legal && hit_e;
    wr_m    = sel_m && writes;
    wr_s    = sel_s && writes;
    wr_e    = sel_e && writes;
  end

endmodule

// File: rtl/csr_envcfg_reg.sv
module csr_envcfg_reg
  import csr_alias_pkg::*;
#(
  parameter int XW = XLEN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_e,
  input  csr_op_e       op,
  input  logic [XW-1:0] wdata,
  output logic [XW-1:0] env_q,
  output logic [XW-1:0] env_view,
  output logic          dte
);

  logic [XW-1:0] env_new;
  logic [XW-1:0] env_d;

  always_comb begin
    env_view = env_q & ENV_IMPL;
    env_new  = csr_rmw(env_view, op, wdata);
    env_d    = wr_e ? merge_masked(env_q, env_new, ENV_IMPL) : env_q;
    dte      = env_q[B_DTE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) env_q <= '0;
    else        env_q <= env_d;
  end

endmodule

// File: rtl/csr_status_reg.sv
module csr_status_reg
  import csr_alias_pkg::*;
#(
  parameter int XW = XLEN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_m,
  input  logic          wr_s,
  input  csr_op_e       op,
  input  logic [XW-1:0] wdata,
  input  logic          dte,
  output logic [XW-1:0] mst_q,
  output logic [XW-1:0] m_view,
  output logic [XW-1:0] s_view,
  output logic          sdt_set_evt,
  output logic          mdt_set_evt,
  output logic          alias_sdt_blocked
);

  logic [XW-1:0] m_new, s_new, src, wmask, merged, mst_d;

  always_comb begin
    m_view = mstatus_view(mst_q);
    s_view = sstatus_view(mst_q, dte);
    m_new  = csr_rmw(m_view, op, wdata);
    s_new  = csr_rmw(s_view, op, wdata);

    if (wr_m) begin
      src   = m_new;
      wmask = MST_IMPL;
    end else if (wr_s) begin
      src   = s_new;
      wmask = sstatus_wmask(dte);
    end else begin
      src   = '0;
      wmask = '0;
    end

    // the alias path carried SDT but the enable held it back
    alias_sdt_blocked = wr_s && !dte;
    sdt_set_evt       = (wr_m && m_new[B_SDT]) || (wr_s && dte && s_new[B_SDT]);
    mdt_set_evt       = wr_m && m_new[B_MDT];

    merged = merge_masked(mst_q, src, wmask);
    mst_d  = merged;
    if (sdt_set_evt) mst_d[B_SIE] = 1'b0;
    if (mdt_set_evt) mst_d[B_MIE] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mst_q <= '0;
    else        mst_q <= mst_d;
  end

endmodule

// File: rtl/csr_status_alias.sv
module csr_status_alias
  import csr_alias_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_op,
  input  logic [XLEN-1:0]   req_wdata,
  input  logic [PRIV_W-1:0] req_priv,
  output logic [XLEN-1:0]   rsp_rdata,
  output logic              rsp_illegal
);

  csr_op_e     op;
  logic        sel_m, sel_s, sel_e;
  logic        wr_m, wr_s, wr_e;
  logic        dte;
  xword_t      env_q, env_view;
  xword_t      mst_q, m_view, s_view;
  logic        sdt_set_evt, mdt_set_evt, alias_sdt_blocked;

  assign op = csr_op_e'(req_op);

  csr_alias_decode #(.AW(ADDR_W), .PW(PRIV_W)) u_dec (
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_op    (op),
    .req_priv  (req_priv),
    .sel_m     (sel_m),
    .sel_s     (sel_s),
    .sel_e     (sel_e),
    .illegal   (rsp_illegal),
    .wr_m      (wr_m),
    .wr_s      (wr_s),
    .wr_e      (wr_e)
  );

  csr_envcfg_reg #(.XW(XLEN)) u_env (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_e     (wr_e),
    .op       (op),
    .wdata    (req_wdata),
    .env_q    (env_q),
    .env_view (env_view),
    .dte      (dte)
  );

  csr_status_reg #(.XW(XLEN)) u_sts (
    .clk               (clk),
    .rst_n             (rst_n),
    .wr_m              (wr_m),
    .wr_s              (wr_s),
    .op                (op),
    .wdata             (req_wdata),
    .dte               (dte),
    .mst_q             (mst_q),
    .m_view            (m_view),
    .s_view            (s_view),
    .sdt_set_evt       (sdt_set_evt),
    .mdt_set_evt       (mdt_set_evt),
    .alias_sdt_blocked (alias_sdt_blocked)
  );

  always_comb begin
    unique case (1'b1)
      sel_m:   rsp_rdata = m_view;
      sel_s:   rsp_rdata = s_view;
      sel_e:   rsp_rdata = env_view;
      default: rsp_rdata = '0;
    endcase
  end

endmodule

// File: rtl/csr_alias_checker.sv
module csr_alias_checker
  import csr_alias_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [XLEN-1:0]   rsp_rdata,
  input logic              rsp_illegal,
  input logic              wr_m,
  input logic              wr_s,
  input logic              wr_e,
  input logic              dte,
  input logic [XLEN-1:0]   mst_q,
  input logic [XLEN-1:0]   env_q,
  input logic              sdt_set_evt,
  input logic              mdt_set_evt,
  input logic              alias_sdt_blocked
);

  AST_WPRI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> $stable(mst_q & ~MST_IMPL)); // R2

  AST_WPRI_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_illegal && req_addr == ADR_MSTATUS) |-> ((rsp_rdata & ~MST_IMPL) == '0)); // R2

  AST_ENVCFG_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_e |=> $stable(mst_q)); // R3

  AST_ALIAS_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_s |=> $stable(mst_q & ~SST_MASK)); // R4

  AST_ALIAS_SDT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    alias_sdt_blocked |=> (mst_q[B_SDT] == $past(mst_q[B_SDT]))); // R6

  AST_SSTATUS_SDT_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_illegal && req_addr == ADR_SSTATUS && !dte) |-> !rsp_rdata[B_SDT]); // R7

  AST_SDT_CLEARS_SIE: assert property (@(posedge clk) disable iff (!rst_n)
    sdt_set_evt |=> (mst_q[B_SDT] && !mst_q[B_SIE])); // R8

  AST_MDT_CLEARS_MIE: assert property (@(posedge clk) disable iff (!rst_n)
    mdt_set_evt |=> (mst_q[B_MDT] && !mst_q[B_MIE])); // R8

  AST_IDLE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(mst_q) && $stable(env_q))); // R9

  AST_ILLEGAL_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_illegal) |=> ($stable(mst_q) && $stable(env_q))); // R10

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal |-> !(wr_m || wr_s || wr_e) && (rsp_rdata == '0)); // R10

endmodule

bind csr_status_alias csr_alias_checker u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .req_valid         (req_valid),
  .req_addr          (req_addr),
  .rsp_rdata         (rsp_rdata),
  .rsp_illegal       (rsp_illegal),
  .wr_m              (wr_m),
  .wr_s              (wr_s),
  .wr_e              (wr_e),
  .dte               (dte),
  .mst_q             (mst_q),
  .env_q             (env_q),
  .sdt_set_evt       (sdt_set_evt),
  .mdt_set_evt       (mdt_set_evt),
  .alias_sdt_blocked (alias_sdt_blocked)
);

// File: tb/csr_status_alias_tb.sv
`timescale 1ns/1ps
module csr_status_alias_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_op = '0;
  logic [63:0] req_wdata = '0;
  logic [1:0]  req_priv = '0;
  logic [63:0] rsp_rdata;
  logic        rsp_illegal;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model state
  logic [63:0] m_st = '0;
  logic [63:0] m_env = '0;
  logic [63:0] last_rd;

  always #2.5 clk = ~clk;

  csr_status_alias dut_i (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_addr (req_addr),
    .req_op (req_op), .req_wdata (req_wdata), .req_priv (req_priv),
    .rsp_rdata (rsp_rdata), .rsp_illegal (rsp_illegal)
  );

  // field sets written as position lists
  function automatic logic [63:0] set_of(input int kind);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      case (kind)
        0: if (i == 1 || i == 3 || i == 5 || i == 7 || i == 8 || i == 18 ||
               i == 19 || i == 24 || i == 42) m[i] = 1'b1;
        1: if (i == 1 || i == 5 || i == 8 || i == 18 || i == 19 || i == 24) m[i] = 1'b1;
        default: if (i == 0 || i == 59) m[i] = 1'b1;
      endcase
    end
    return m;
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one access: drive at negedge, sample before the rising edge, then update the model
  task automatic access(input bit v, input logic [11:0] a, input logic [1:0] op,
                        input logic [63:0] d, input logic [1:0] p, input string tag);
    bit ok, is_m, is_s, is_e, dte;
    logic [63:0] oldv, newv, exp_rd;
    @(negedge clk);
    req_valid = v; req_addr = a; req_op = op; req_wdata = d; req_priv = p;
    dte  = m_env[59];
    is_m = (a == 12'h300); is_s = (a == 12'h100); is_e = (a == 12'h30A);
    ok   = v && ((is_m && p == 2'd3) || (is_e && p == 2'd3) ||
                 (is_s && (p == 2'd1 || p == 2'd3)));
    oldv = '0;
    if (ok && is_m) oldv = m_st & set_of(0);
    if (ok && is_s) begin
      oldv = m_st & set_of(1);
      if (!dte) oldv[24] = 1'b0;
    end
    if (ok && is_e) oldv = m_env & set_of(2);
    exp_rd = oldv;
    #1;
    check(rsp_rdata, exp_rd, {tag, " rdata"});
    check({63'd0, rsp_illegal}, {63'd0, v && !ok}, {tag, " illegal"});
    last_rd = rsp_rdata;
    if (ok && op != 2'd0) begin
      case (op)
        2'd1: newv = d;
        2'd2: newv = oldv | d;
        default: newv = oldv & ~d;
      endcase
      if (is_m) begin
        for (int i = 0; i < 64; i++) if (set_of(0)[i]) m_st[i] = newv[i];
        if (newv[24]) m_st[1] = 1'b0;
        if (newv[42]) m_st[3] = 1'b0;
      end else if (is_s) begin
        for (int i = 0; i < 64; i++)
          if (set_of(1)[i] && (i != 24 || dte)) m_st[i] = newv[i];
        if (dte && newv[24]) m_st[1] = 1'b0;
      end else begin
        for (int i = 0; i < 64; i++) if (set_of(2)[i]) m_env[i] = newv[i];
      end
    end
    @(posedge clk);
  endtask

  task automatic rd_m(input string tag);
    access(1'b1, 12'h300, 2'd0, 64'd0, 2'd3, tag);
  endtask

  initial begin
    repeat (2000 * 100) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] snap;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd_m("R1 mstatus reset");
    check(last_rd, 64'd0, "R1 mstatus zero");
    access(1'b1, 12'h30A, 2'd0, 64'd0, 2'd3, "R1 menvcfg reset");
    check(last_rd, 64'd0, "R1 menvcfg zero");

    // R5 direct SDT write with DTE off, R8 SIE dropped
    access(1'b1, 12'h300, 2'd1, (64'd1 << 24) | 64'd2, 2'd3, "R5 direct sdt");
    rd_m("R5 readback");
    check(last_rd, 64'd1 << 24, "R5 sdt set, R8 sie cleared");

    // R7 hidden in supervisor view, R6 held on alias write
    access(1'b1, 12'h100, 2'd0, 64'd0, 2'd1, "R7 sstatus read");
    check(last_rd[24], 1'b0, "R7 sdt hidden");
    access(1'b1, 12'h100, 2'd1, 64'd0, 2'd1, "R6 alias write zero");
    rd_m("R6 readback");
    check(last_rd[24], 1'b1, "R6 sdt held not zeroed");
    access(1'b1, 12'h100, 2'd2, (64'd1 << 24) | 64'd2, 2'd1, "R6 alias set blocked");
    rd_m("R6 readback2");
    check(last_rd, (64'd1 << 24) | 64'd2, "R6 sie set, sdt unchanged");

    // R3 environment writes leave status alone; enable DTE
    snap = m_st;
    access(1'b1, 12'h30A, 2'd1, '1, 2'd3, "R3 env write ones");
    access(1'b1, 12'h30A, 2'd3, 64'd1, 2'd3, "R3 env clear");
    access(1'b1, 12'h30A, 2'd2, 64'd1 << 59, 2'd3, "R3 env set dte");
    rd_m("R3 readback");
    check(last_rd, snap, "R3 status untouched");

    // R6 alias now effective
    access(1'b1, 12'h100, 2'd3, 64'd1 << 24, 2'd1, "R6 alias clear sdt");
    rd_m("R6 readback3");
    check(last_rd[24], 1'b0, "R6 sdt cleared with dte");
    access(1'b1, 12'h100, 2'd2, (64'd1 << 24) | 64'd2, 2'd1, "R8 alias set sdt");
    rd_m("R8 readback");
    check(last_rd[1:0], 2'b00, "R8 sie cleared by alias sdt");

    // R4 alias scope
    access(1'b1, 12'h300, 2'd2, (64'd1 << 3) | (64'd1 << 7), 2'd3, "R4 prep");
    access(1'b1, 12'h100, 2'd1, '1, 2'd3, "R4 alias ones");
    rd_m("R4 readback");
    check(last_rd, ((64'd1 << 3) | (64'd1 << 7) | set_of(1)) & ~64'd2, "R4 scope");

    // R8 MDT drops MIE
    access(1'b1, 12'h300, 2'd2, 64'd1 << 42, 2'd3, "R8 mdt set");
    rd_m("R8 readback2");
    check(last_rd[3], 1'b0, "R8 mie cleared");

    // R2 reserved bits
    access(1'b1, 12'h300, 2'd1, '1, 2'd3, "R2 write ones");
    rd_m("R2 readback");
    check(last_rd & ~set_of(0), 64'd0, "R2 wpri read zero");

    // R10 illegal accesses
    snap = m_st;
    access(1'b1, 12'h100, 2'd1, 64'd0, 2'd0, "R10 user sstatus");
    access(1'b1, 12'h300, 2'd1, 64'd0, 2'd1, "R10 super mstatus");
    access(1'b1, 12'h30A, 2'd1, 64'd0, 2'd1, "R10 super menvcfg");
    access(1'b1, 12'h305, 2'd1, 64'd0, 2'd3, "R10 unknown addr");
    rd_m("R10 readback");
    check(last_rd, snap, "R10 no state change");

    // R9 idle and read-only
    access(1'b0, 12'h300, 2'd1, 64'd0, 2'd3, "R9 idle");
    access(1'b1, 12'h300, 2'd0, 64'd0, 2'd3, "R9 read only");
    rd_m("R9 readback");
    check(last_rd, snap, "R9 no change");

    // R11 and all: random sweep against the model
    for (int k = 0; k < 4000; k++) begin
      logic [11:0] a;
      logic [1:0]  p;
      logic [63:0] d;
      case ($urandom_range(0, 4))
        0: a = 12'h300; 1: a = 12'h100; 2: a = 12'h30A; 3: a = 12'h100; default: a = 12'h305;
      endcase
      case ($urandom_range(0, 3))
        0: p = 2'd0; 1: p = 2'd1; default: p = 2'd3;
      endcase
      case ($urandom_range(0, 3))
        0: d = {$urandom, $urandom};
        1: d = (64'd1 << 24) | (64'($urandom_range(0, 1)) << 1);
        2: d = 64'd1 << 59;
        default: d = 64'd1 << $urandom_range(0, 63);
      endcase
      access($urandom_range(0, 7) != 0, a, 2'($urandom_range(0, 3)), d, p, "R11 sweep");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule